// File: doc/BRIEF.md
# Zero-Crossing Soft Mute Controller

This block sits in a stereo sample path and decides the exact sample at which a mute request takes effect. The request is one active-high level that covers both channels. Each channel keeps passing audio until its own waveform crosses zero, and it is gated from that sample onward. Releasing the request restores each channel the same way. Switching at a crossing keeps the step in the output small, which keeps the audible pop small.

If a channel finds no crossing, a count of sample strobes bounds the wait. With the default limit of 1024 strobes, the longest wait at a 44.1 kHz rate is about 23 ms of audio. Samples arrive with a one-cycle strobe. Each one leaves the block one clock later, either unchanged or forced to zero. A status flag reports when both channels are actually muted.

Top module: `zc_soft_mute`

## Requirements
- R1: After reset, `out_valid`, `out_left`, `out_right` and `muted` are 0. Both channels are in the pass state, and the stored sign of each channel is non-negative.
- R2: `out_valid` is `smp_valid` delayed by one clock. A channel in the pass state outputs its sample unchanged one clock after the strobe.
- R3: `mute_req` = 1 asks both channels to mute, and `mute_req` = 0 asks both to pass. A channel only ever switches to the state that the request held in the cycle of the switch.
- R4: A crossing on a strobe occurs when that channel's sample is zero, or when its sign bit (bit W-1) differs from the sign bit of the channel's previous strobed sample.
- R5: A channel whose state differs from the request switches on its own crossing strobe. The sample of that strobe is already output in the new state, and the two channels switch independently.
- R6: A channel still pending is forced to the requested state on the TIMEOUT-th strobe (default 1024) counted since the last change of `mute_req` level. A strobe in the cycle of the change counts as the first.
- R7: The strobe count restarts whenever `mute_req` changes level, even when no strobe arrives between the changes. Cycles without a strobe do not advance it.
- R8: A channel in the mute state outputs 0 on every strobe.
- R9: `muted` is 1 exactly when both channels are in the mute state. It changes in the clock after the strobe that completes the switch.
- R10: A release restores each channel at its own crossing or on the timeout, under the same rules as muting.
- R11: Between strobes, neither channel changes state and the output data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mute_req | input | 1 | Mute request for both channels, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| out_valid | output | 1 | Strobe for the gated sample pair |
| out_left | output | W | Gated left sample |
| out_right | output | W | Gated right sample |
| muted | output | 1 | Both channels are muted |

## Verification
A wrong stored sign bit shows on the next strobe. The channel then switches one sample early or late, and the zeroed sample appears at the wrong place in the output. A strobe counter that is off by one, or that fails to restart, only shows when the timeout fires. That takes up to TIMEOUT strobes, so the bench feeds long runs with no crossing, both with and without restarts of the request level. A gate state that is wrong between strobes stays hidden until the next strobe or the `muted` flag exposes it. For that reason the outputs are compared against a model on every clock.

// File: rtl/zc_soft_mute.sv
module zc_soft_mute #(
  parameter int W       = 16,
  parameter int TIMEOUT = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mute_req,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_left,
  input  logic signed [W-1:0] smp_right,
  output logic                out_valid,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right,
  output logic                muted
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          req_q;
  logic [CW-1:0] cnt;
  logic          gl, gr;
  logic          sl, sr;

  wire          chg  = mute_req ^ req_q;
  wire [CW-1:0] base = chg ? '0 : cnt;
  wire          force_now = smp_valid && (base == LIMIT - 1'b1);

  wire xl = (smp_left  == '0) || (smp_left[W-1]  != sl);
  wire xr = (smp_right == '0) || (smp_right[W-1] != sr);

  wire gl_n = (smp_valid && (gl != mute_req) && (xl || force_now)) ? mute_req : gl;
  wire gr_n = (smp_valid && (gr != mute_req) && (xr || force_now)) ? mute_req : gr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      cnt       <= '0;
      gl        <= 1'b0;
      gr        <= 1'b0;
      sl        <= 1'b0;
      sr        <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      req_q     <= mute_req;
      out_valid <= smp_valid;
      gl        <= gl_n;
      gr        <= gr_n;
      if (smp_valid) begin
        cnt       <= (base == LIMIT) ? LIMIT : base + 1'b1;
        sl        <= smp_left[W-1];
        sr        <= smp_right[W-1];
        out_left  <= gl_n ? '0 : smp_left;
        out_right <= gr_n ? '0 : smp_right;
      end else begin
        cnt <= base;
      end
    end
  end

  assign muted = gl & gr;

  a_r11_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(gl) && $stable(gr) && $stable(out_left) && $stable(out_right)));

  a_r8_zero_left: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && gl) |-> (out_left == '0));

  a_r8_zero_right: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && gr) |-> (out_right == '0));

  a_r3_follow_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((gl != $past(gl)) || (gr != $past(gr))) |->
      ((gl != $past(gl) -> gl == $past(mute_req)) && (gr != $past(gr) -> gr == $past(mute_req))));

  a_r6_no_pending_after_force: assert property (@(posedge clk) disable iff (!rst_n)
    force_now |=> (gl == $past(mute_req) && gr == $past(mute_req)));

  a_r9_muted_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(smp_valid));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
endmodule

// File: tb/test_zc_soft_mute.sv
`timescale 1ns/1ps
module test_zc_soft_mute;
  localparam int W  = 16;
  localparam int TO = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute_req = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] smp_left = '0, smp_right = '0;
  logic out_valid, muted;
  logic signed [W-1:0] out_left, out_right;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  zc_soft_mute #(.W(W), .TIMEOUT(TO)) i_zc_soft_mute (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .muted(muted));

  // behavioural reference
  bit m_gl, m_gr, m_sl, m_sr, m_req, e_v;
  int m_cnt;
  int e_l, e_r;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gl = 0; m_gr = 0; m_sl = 0; m_sr = 0; m_req = 0; m_cnt = 0;
      e_v = 0; e_l = 0; e_r = 0;
    end else begin
      if (mute_req != m_req) m_cnt = 0;
      m_req = mute_req;
      e_v = smp_valid;
      if (smp_valid) begin
        int n;
        bit cl, cr;
        n  = m_cnt + 1;
        cl = (smp_left == 0)  || ((smp_left < 0)  != m_sl);
        cr = (smp_right == 0) || ((smp_right < 0) != m_sr);
        if (m_gl != mute_req && (cl || n == TO)) m_gl = mute_req;
        if (m_gr != mute_req && (cr || n == TO)) m_gr = mute_req;
        e_l = m_gl ? 0 : int'(smp_left);
        e_r = m_gr ? 0 : int'(smp_right);
        m_sl = smp_left < 0;
        m_sr = smp_right < 0;
        m_cnt = (n > TO) ? TO : n;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(out_valid == e_v, "R2 out_valid", int'(out_valid), int'(e_v));
    chk(int'(out_left) == e_l, "R5/R8 out_left model", int'(out_left), e_l);
    chk(int'(out_right) == e_r, "R5/R8 out_right model", int'(out_right), e_r);
    chk(muted == (m_gl && m_gr), "R9 muted model", int'(muted), int'(m_gl && m_gr));
  end

  task automatic strobe(input int l, input int r);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = W'(l); smp_right = W'(r);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic set_req(input bit v);
    @(negedge clk);
    mute_req = v;
  endtask

  task automatic see(input string tag, input int l, input int r, input bit m);
    chk(int'(out_left) == l, tag, int'(out_left), l);
    chk(int'(out_right) == r, tag, int'(out_right), r);
    chk(muted == m, tag, int'(muted), int'(m));
  endtask

  initial begin
    #700000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_left == 0 && out_right == 0 && muted == 0, "R1 reset state",
        int'(out_valid) + int'(muted), 0);
    rst_n = 1'b1;
    strobe(1000, -500);
    see("R2 pass through", 1000, -500, 0);
    set_req(1);
    strobe(900, -400);
    see("R5 pending without crossing", 900, -400, 0);
    strobe(-50, -300);
    see("R4 R5 left sign crossing", 0, -300, 0);
    repeat (3) @(negedge clk);
    see("R11 idle hold", 0, -300, 0);
    chk(out_valid == 0, "R11 no strobe", int'(out_valid), 0);
    strobe(-60, 0);
    see("R4 R9 right zero sample", 0, 0, 1);
    strobe(-70, 0);
    see("R8 muted zero", 0, 0, 1);
    set_req(0);
    strobe(-70, 5);
    see("R10 release waits", 0, 0, 1);
    strobe(30, 7);
    see("R10 left restored", 30, 0, 0);
    strobe(-2, -8);
    see("R10 right restored", -2, -8, 0);
    set_req(1);
    for (int i = 1; i < TO; i++) strobe(-100, -200);
    see("R6 before timeout", -100, -200, 0);
    strobe(-100, -200);
    see("R6 forced by timeout", 0, 0, 1);
    set_req(0);
    for (int i = 0; i < 600; i++) strobe(-100, -200);
    set_req(1);
    set_req(0);
    for (int i = 0; i < 600; i++) strobe(-100, -200);
    see("R7 count restarted", 0, 0, 1);
    for (int i = 0; i < TO - 601; i++) strobe(-100, -200);
    see("R7 one before limit", 0, 0, 1);
    strobe(-100, -200);
    see("R7 R10 release by timeout", -100, -200, 0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule